// File: doc/BRIEF.md
# Coalesced Request Tracking Table

This block sits next to a memory request coalescer. When the coalescer issues one wide request in place of several narrow per-lane requests, it also reports two things: which request-queue slots were folded into that request, as a bitmap of lanes by queue slots, and a snapshot of every queue slot. The block turns these into a table entry and stores it under the new source ID of the wide request. For each folded slot, the entry keeps the original source ID, the word offset inside the wide beat, the encoded access size and the operation.

When the wide response returns, the block looks up the entry by the response's source ID. The cycle after the lookup it drives a lanes-by-slots array of responses. Each valid slot carries its original source ID and the part of the beat that slot asked for. A lookup frees the entry so that its source ID can be used again. Every response is a single beat, because the largest coalesced size never exceeds the data bus width.

Top module: `tracktab_top`

## Requirements
- R1: After synchronous reset, every per-slot output valid bit is low, the miss flag is low, and no table entry is live, so any lookup misses.
- R2: When a request is recorded, a slot is marked valid only if the invalidate-valid input is high and that slot's invalidate bit is high. The slot's original ID, address-derived offset, size and op are taken from the same slot of the window snapshot. Slot index is lane*DEPTH + queue position.
- R3: The stored word offset is the request address modulo 2^MAX_COAL_LOG (16 bytes), divided by the word size 2^WORD_LOG (4 bytes).
- R4: Both ready outputs are always high. An entry is written under `req_new_id` on every cycle in which `req_valid` is high, even when no slot is marked.
- R5: On a cycle with `rsp_valid` high, the entry at `rsp_id` is read. The per-slot outputs present the result on the following cycle.
- R6: Recording and looking up the same source ID in the same cycle is not supported and is flagged by an assertion.
- R7: The table holds NEW_IDS independent entries, one per new source ID. Writing one ID leaves the others unchanged.
- R8: A hit drives `out_valid` equal to the entry's slot valid bits for exactly one cycle, with each valid slot's original ID, size code and op. In any other cycle `out_valid` is zero.
- R9: A valid slot's data is the beat's 32-bit word at the slot's word offset (word k is beat bits [32k+31:32k]), cut to 2^size bytes and zero-extended. Size codes are 0=1 byte, 1=2 bytes, 2 or more=full word.
- R10: A hit clears the entry's live flag, so a second lookup of the same ID misses unless the ID was written again in between.
- R11: A lookup of an entry that is not live sets `miss_err` on the next cycle and produces no valid slot output. `miss_err` then stays high until reset.
- R12: Writing an ID that is already live replaces the whole entry with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A coalesced request is being issued |
| req_ready | output | 1 | Always high |
| req_new_id | input | NEW_ID_W (2) | Source ID of the coalesced request |
| inv_valid | input | 1 | The invalidate bitmap is valid |
| inv_bits | input | SLOTS (8) | Folded-slot bitmap, bit lane*DEPTH+pos |
| win_old_id | input | SLOTS*OLD_ID_W (32) | Per-slot original source IDs |
| win_addr | input | SLOTS*ADDR_W (128) | Per-slot request addresses |
| win_size | input | SLOTS*SIZE_W (16) | Per-slot log2 size codes |
| win_op | input | SLOTS (8) | Per-slot op, 0 read, 1 write |
| rsp_valid | input | 1 | Wide response present |
| rsp_ready | output | 1 | Always high |
| rsp_id | input | NEW_ID_W (2) | Source ID of the wide response |
| rsp_data | input | BEAT_BITS (128) | Wide response beat |
| out_valid | output | SLOTS (8) | Per-slot response valid |
| out_old_id | output | SLOTS*OLD_ID_W (32) | Per-slot original source ID |
| out_data | output | SLOTS*WORD_BITS (256) | Per-slot zero-extended data |
| out_size | output | SLOTS*SIZE_W (16) | Per-slot size code |
| out_op | output | SLOTS (8) | Per-slot op |
| miss_err | output | 1 | Sticky lookup-miss flag |

## Verification
The bench aims at the offset arithmetic with addresses in the top word of a beat and with addresses whose byte part is not aligned. A design that got the modulo or the shift wrong would return a neighbouring word. Sub-word sizes are mixed with full words, so a missing mask shows up as stray upper bits. Bitmaps are recorded with invalidate-valid low, IDs are looked up twice, live IDs are rewritten, and reads go to untouched IDs. A design that ignored invalidate-valid, did not free entries, or merged old and new entries would raise phantom valid bits or miss the sticky miss flag. Random writes and lookups of different IDs in the same cycle show whether a clear and a write interfere with each other.

// File: rtl/tracktab_pkg.sv
package tracktab_pkg;
    parameter int LANES        = 4;
    parameter int DEPTH        = 2;
    parameter int OLD_ID_W     = 4;
    parameter int NEW_IDS      = 4;
    parameter int ADDR_W       = 16;
    parameter int SIZE_W       = 2;
    parameter int WORD_LOG     = 2;
    parameter int MAX_COAL_LOG = 4;

    localparam int SLOTS     = LANES * DEPTH;
    localparam int NEW_ID_W  = (NEW_IDS > 1) ? $clog2(NEW_IDS) : 1;
    localparam int WORD_BITS = 8 << WORD_LOG;
    localparam int BEAT_BITS = 8 << MAX_COAL_LOG;
    localparam int OFF_W     = MAX_COAL_LOG - WORD_LOG;

    typedef struct packed {
        logic                vld;
        logic [OLD_ID_W-1:0] old_id;
        logic [OFF_W-1:0]    off;
        logic [SIZE_W-1:0]   lsize;
        logic                op;
    } slot_t;

    typedef struct packed {
        logic                live;
        logic [NEW_ID_W-1:0] id;
        slot_t [SLOTS-1:0]   slots;
    } entry_t;

    // word index of an address inside one wide beat
    function automatic logic [OFF_W-1:0] word_offset(input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0] inbeat;
        inbeat = addr & ADDR_W'((1 << MAX_COAL_LOG) - 1);
        return OFF_W'(inbeat >> WORD_LOG);
    endfunction

    // pick one word of the beat and keep only the requested bytes
    function automatic logic [WORD_BITS-1:0] cut_chunk(
        input logic [BEAT_BITS-1:0] beat,
        input logic [OFF_W-1:0]     off,
        input logic [SIZE_W-1:0]    lsize
    );
        logic [WORD_BITS-1:0] word;
        logic [WORD_BITS-1:0] keep;
        word = beat[int'(off) * WORD_BITS +: WORD_BITS];
        if (int'(lsize) >= WORD_LOG)
            keep = '1;
        else
            keep = (WORD_BITS'(1) << (8 << lsize)) - WORD_BITS'(1);
        return word & keep;
    endfunction
endpackage

// File: rtl/tracktab_entry_build.sv
module tracktab_entry_build
    import tracktab_pkg::*;
(
    input  logic [NEW_ID_W-1:0]       new_id,
    input  logic                      inv_valid,
    input  logic [SLOTS-1:0]          inv_bits,
    input  logic [SLOTS*OLD_ID_W-1:0] win_old_id,
    input  logic [SLOTS*ADDR_W-1:0]   win_addr,
    input  logic [SLOTS*SIZE_W-1:0]   win_size,
    input  logic [SLOTS-1:0]          win_op,
    output entry_t                    entry
);
    slot_t [SLOTS-1:0] slot_w;

    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            assign slot_w[s].vld    = inv_valid & inv_bits[s];
            assign slot_w[s].old_id = win_old_id[s*OLD_ID_W +: OLD_ID_W];
            assign slot_w[s].off    = word_offset(win_addr[s*ADDR_W +: ADDR_W]);
            assign slot_w[s].lsize  = win_size[s*SIZE_W +: SIZE_W];
            assign slot_w[s].op     = win_op[s];
        end
    endgenerate

    always_comb begin
        entry.live  = 1'b1;
        entry.id    = new_id;
        entry.slots = slot_w;
    end
endmodule

// File: rtl/tracktab_store.sv
module tracktab_store
    import tracktab_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  entry_t              wr_entry,
    input  logic                rd_en,
    input  logic [NEW_ID_W-1:0] rd_id,
    output entry_t              rd_entry,
    output logic                rd_hit
);
    entry_t mem [NEW_IDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NEW_IDS; i++) mem[i] <= '0;
        end else begin
            if (rd_en && mem[rd_id].live) mem[rd_id].live <= 1'b0;
            if (wr_en) mem[wr_entry.id] <= wr_entry;
        end
    end

    assign rd_entry = mem[rd_id];
    assign rd_hit   = rd_en & rd_entry.live;

    // R6: same ID written and looked up in one cycle is unsupported
    a_r6_no_collision: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en && (wr_entry.id == rd_id)));

    // R10: a hit frees the entry
    a_r10_freed: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_entry.live && !(wr_en && wr_entry.id == rd_id))
        |=> !mem[$past(rd_id)].live);

    // R7: a write lands under its own ID
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_entry.id)].live && mem[$past(wr_entry.id)].id == $past(wr_entry.id)));

    // R7: a hit returns the entry stored for that ID
    a_r7_id_match: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (rd_entry.id == rd_id));
endmodule

// File: rtl/tracktab_slicer.sv
module tracktab_slicer
    import tracktab_pkg::*;
(
    input  logic [BEAT_BITS-1:0]       beat,
    input  entry_t                     entry,
    output logic [SLOTS*WORD_BITS-1:0] chunks
);
    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_cut
            assign chunks[s*WORD_BITS +: WORD_BITS] =
                cut_chunk(beat, entry.slots[s].off, entry.slots[s].lsize);
        end
    endgenerate
endmodule

// File: rtl/tracktab_top.sv
module tracktab_top
    import tracktab_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [NEW_ID_W-1:0]        req_new_id,
    input  logic                       inv_valid,
    input  logic [SLOTS-1:0]           inv_bits,
    input  logic [SLOTS*OLD_ID_W-1:0]  win_old_id,
    input  logic [SLOTS*ADDR_W-1:0]    win_addr,
    input  logic [SLOTS*SIZE_W-1:0]    win_size,
    input  logic [SLOTS-1:0]           win_op,
    input  logic                       rsp_valid,
    output logic                       rsp_ready,
    input  logic [NEW_ID_W-1:0]        rsp_id,
    input  logic [BEAT_BITS-1:0]       rsp_data,
    output logic [SLOTS-1:0]           out_valid,
    output logic [SLOTS*OLD_ID_W-1:0]  out_old_id,
    output logic [SLOTS*WORD_BITS-1:0] out_data,
    output logic [SLOTS*SIZE_W-1:0]    out_size,
    output logic [SLOTS-1:0]           out_op,
    output logic                       miss_err
);
    entry_t                     new_entry;
    entry_t                     hit_entry;
    logic                       hit;
    logic [SLOTS*WORD_BITS-1:0] chunks;

    assign req_ready = 1'b1;
    assign rsp_ready = 1'b1;

    tracktab_entry_build u_build (
        .new_id     (req_new_id),
        .inv_valid  (inv_valid),
        .inv_bits   (inv_bits),
        .win_old_id (win_old_id),
        .win_addr   (win_addr),
        .win_size   (win_size),
        .win_op     (win_op),
        .entry      (new_entry)
    );

    tracktab_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req_valid),
        .wr_entry (new_entry),
        .rd_en    (rsp_valid),
        .rd_id    (rsp_id),
        .rd_entry (hit_entry),
        .rd_hit   (hit)
    );

    tracktab_slicer u_slicer (
        .beat   (rsp_data),
        .entry  (hit_entry),
        .chunks (chunks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= '0;
            out_old_id <= '0;
            out_data   <= '0;
            out_size   <= '0;
            out_op     <= '0;
            miss_err   <= 1'b0;
        end else begin
            out_data <= chunks;
            for (int s = 0; s < SLOTS; s++) begin
                out_valid[s]                      <= hit & hit_entry.slots[s].vld;
                out_old_id[s*OLD_ID_W +: OLD_ID_W] <= hit_entry.slots[s].old_id;
                out_size[s*SIZE_W +: SIZE_W]       <= hit_entry.slots[s].lsize;
                out_op[s]                         <= hit_entry.slots[s].op;
            end
            if (rsp_valid && !hit_entry.live) miss_err <= 1'b1;
        end
    end

    // R8: slot outputs only follow a lookup cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> $past(rsp_valid));

    // R11: a miss yields no slot outputs and raises the flag
    a_r11_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !hit) |=> (out_valid == '0 && miss_err));

    // R11: the flag is sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(miss_err)) |-> miss_err);

    // R5: nothing comes out without a lookup in the previous cycle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> (out_valid == '0));
endmodule

// File: tb/tracktab_top_bench.sv
module tracktab_top_bench;
    import tracktab_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       req_valid = 1'b0;
    logic                       req_ready;
    logic [NEW_ID_W-1:0]        req_new_id = '0;
    logic                       inv_valid = 1'b0;
    logic [SLOTS-1:0]           inv_bits = '0;
    logic [SLOTS*OLD_ID_W-1:0]  win_old_id;
    logic [SLOTS*ADDR_W-1:0]    win_addr;
    logic [SLOTS*SIZE_W-1:0]    win_size;
    logic [SLOTS-1:0]           win_op;
    logic                       rsp_valid = 1'b0;
    logic                       rsp_ready;
    logic [NEW_ID_W-1:0]        rsp_id = '0;
    logic [BEAT_BITS-1:0]       rsp_data = '0;
    logic [SLOTS-1:0]           out_valid;
    logic [SLOTS*OLD_ID_W-1:0]  out_old_id;
    logic [SLOTS*WORD_BITS-1:0] out_data;
    logic [SLOTS*SIZE_W-1:0]    out_size;
    logic [SLOTS-1:0]           out_op;
    logic                       miss_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    tracktab_top u_tracktab_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_new_id(req_new_id),
        .inv_valid(inv_valid), .inv_bits(inv_bits),
        .win_old_id(win_old_id), .win_addr(win_addr), .win_size(win_size), .win_op(win_op),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_old_id(out_old_id), .out_data(out_data),
        .out_size(out_size), .out_op(out_op), .miss_err(miss_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side window and reference table
    logic [OLD_ID_W-1:0] w_old  [SLOTS];
    logic [ADDR_W-1:0]   w_addr [SLOTS];
    logic [SIZE_W-1:0]   w_size [SLOTS];
    logic                w_op   [SLOTS];

    bit                  m_live [NEW_IDS];
    bit                  m_vld  [NEW_IDS][SLOTS];
    logic [OLD_ID_W-1:0] m_old  [NEW_IDS][SLOTS];
    logic [ADDR_W-1:0]   m_addr [NEW_IDS][SLOTS];
    logic [SIZE_W-1:0]   m_size [NEW_IDS][SLOTS];
    logic                m_op   [NEW_IDS][SLOTS];
    bit                  exp_err;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R3 and R9 reference: word index from address, then bytes by size code
    function automatic logic [WORD_BITS-1:0] ref_chunk(input logic [BEAT_BITS-1:0] beat,
                                                       input logic [ADDR_W-1:0] addr,
                                                       input logic [SIZE_W-1:0] sz);
        int widx;
        int nbits;
        logic [BEAT_BITS-1:0] sh;
        logic [WORD_BITS-1:0] r;
        widx  = (int'(addr) % (1 << MAX_COAL_LOG)) / (1 << WORD_LOG);
        sh    = beat >> (widx * WORD_BITS);
        r     = sh[WORD_BITS-1:0];
        nbits = (int'(sz) >= WORD_LOG) ? WORD_BITS : 8 * (1 << sz);
        for (int b = nbits; b < WORD_BITS; b++) r[b] = 1'b0;
        return r;
    endfunction

    task automatic pack_window();
        for (int s = 0; s < SLOTS; s++) begin
            win_old_id[s*OLD_ID_W +: OLD_ID_W] = w_old[s];
            win_addr[s*ADDR_W +: ADDR_W]       = w_addr[s];
            win_size[s*SIZE_W +: SIZE_W]       = w_size[s];
            win_op[s]                          = w_op[s];
        end
    endtask

    task automatic rand_window();
        for (int s = 0; s < SLOTS; s++) begin
            w_old[s]  = OLD_ID_W'($urandom);
            w_addr[s] = ADDR_W'($urandom);
            w_size[s] = SIZE_W'($urandom_range(0, 3));
            w_op[s]   = 1'($urandom);
        end
    endtask

    function automatic logic [BEAT_BITS-1:0] rand_beat();
        logic [BEAT_BITS-1:0] b;
        for (int i = 0; i < BEAT_BITS/32; i++) b[i*32 +: 32] = $urandom;
        return b;
    endfunction

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        rsp_valid = 1'b0;
        inv_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; rsp_valid = 1'b0; inv_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 0; i < NEW_IDS; i++) m_live[i] = 1'b0;
        exp_err = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(out_valid == '0, "R1", "out_valid after reset", 256'(out_valid), 0);
        check(miss_err == 1'b0, "R1", "miss_err after reset", 256'(miss_err), 0);
    endtask

    // one cycle: optional record and optional lookup (ids differ, R6)
    task automatic step(input bit wr, input int wid, input bit iv, input logic [SLOTS-1:0] ib,
                        input bit rd, input int rid, input logic [BEAT_BITS-1:0] beat);
        logic [SLOTS-1:0] ev;
        bit hit;
        @(negedge clk);
        pack_window();
        req_valid = wr; req_new_id = NEW_ID_W'(wid); inv_valid = iv; inv_bits = ib;
        rsp_valid = rd; rsp_id = NEW_ID_W'(rid); rsp_data = beat;
        hit = rd && m_live[rid];
        ev  = '0;
        if (hit) for (int s = 0; s < SLOTS; s++) ev[s] = m_vld[rid][s];
        if (rd && !hit) exp_err = 1'b1;
        @(posedge clk);
        #1;
        // R4: ready outputs
        check(req_ready && rsp_ready, "R4", "ready outputs", 256'({req_ready, rsp_ready}), 3);
        // R5 R8 R11: slot valid pulse and miss flag
        check(out_valid == ev, "R8", "out_valid", 256'(out_valid), 256'(ev));
        check(miss_err == exp_err, "R11", "miss_err", 256'(miss_err), 256'(exp_err));
        if (hit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (m_vld[rid][s]) begin
                    logic [WORD_BITS-1:0] ed;
                    ed = ref_chunk(beat, m_addr[rid][s], m_size[rid][s]);
                    check(out_old_id[s*OLD_ID_W +: OLD_ID_W] == m_old[rid][s], "R2", "old id",
                          256'(out_old_id[s*OLD_ID_W +: OLD_ID_W]), 256'(m_old[rid][s]));
                    check(out_size[s*SIZE_W +: SIZE_W] == m_size[rid][s] && out_op[s] == m_op[rid][s],
                          "R8", "size/op", 256'({out_size[s*SIZE_W +: SIZE_W], out_op[s]}),
                          256'({m_size[rid][s], m_op[rid][s]}));
                    check(out_data[s*WORD_BITS +: WORD_BITS] == ed, "R9", "chunk data",
                          256'(out_data[s*WORD_BITS +: WORD_BITS]), 256'(ed));
                end
            end
            m_live[rid] = 1'b0; // R10
        end
        if (wr) begin // R4 R7 R12
            m_live[wid] = 1'b1;
            for (int s = 0; s < SLOTS; s++) begin
                m_vld[wid][s]  = iv && ib[s]; // R2
                m_old[wid][s]  = w_old[s];
                m_addr[wid][s] = w_addr[s];
                m_size[wid][s] = w_size[s];
                m_op[wid][s]   = w_op[s];
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [BEAT_BITS-1:0] beat;
        seed = $urandom(32'd4711);
        rand_window();
        pack_window();
        do_reset();

        // R1: lookup right after reset misses
        step(0, 0, 0, '0, 1, 0, rand_beat());
        do_reset();

        // R3 R9: directed offsets and sizes
        rand_window();
        w_addr[0] = 16'h0004; w_size[0] = 2'd2;  // word 1, full word
        w_addr[3] = 16'h003E; w_size[3] = 2'd1;  // word 3, two bytes
        w_addr[5] = 16'h000B; w_size[5] = 2'd0;  // word 2, one byte
        w_addr[7] = 16'hFFF0; w_size[7] = 2'd3;  // word 0, code 3 is full word
        step(1, 1, 1, 8'b1010_1001, 0, 0, '0);
        beat = 128'hDDDD_C3C2_BBBB_B2B1_AAAA_A1A0_9999_9190;
        step(0, 0, 0, '0, 1, 1, beat);

        // R2 R4: recorded with invalidate-valid low, still live but no slots
        rand_window();
        step(1, 2, 0, '1, 0, 0, '0);
        step(0, 0, 0, '0, 1, 2, rand_beat());
        check(miss_err == 1'b0, "R4", "entry with no slots still live", 256'(miss_err), 0);

        // R10 R11: second lookup of a freed ID misses, flag sticks
        step(0, 0, 0, '0, 1, 1, rand_beat());
        idle();
        @(posedge clk); #1;
        check(miss_err == 1'b1, "R11", "miss_err sticky", 256'(miss_err), 1);
        check(out_valid == '0, "R8", "no pulse after idle", 256'(out_valid), 0);

        // R12: rewrite a live ID, lookup returns the newer entry
        do_reset();
        rand_window();
        step(1, 3, 1, 8'hFF, 0, 0, '0);
        rand_window();
        step(1, 3, 1, 8'h3C, 0, 0, '0);
        step(0, 0, 0, '0, 1, 3, rand_beat());

        // R7: random mix of records and lookups on different IDs (R6 kept)
        do_reset();
        for (int n = 0; n < 400; n++) begin
            bit wr, rd;
            int wid, rid;
            rand_window();
            wr  = 1'($urandom);
            rd  = ($urandom_range(0, 2) == 0);
            wid = $urandom_range(0, NEW_IDS-1);
            rid = $urandom_range(0, NEW_IDS-1);
            if (wr && rd && wid == rid) rid = (rid + 1) % NEW_IDS;
            step(wr, wid, 1'($urandom_range(0, 5) != 0), SLOTS'($urandom), rd, rid, rand_beat());
            if (n == 200) do_reset();
        end
        idle();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule